// File: doc/BRIEF.md
# DDR2 Initialization Sequencer

This block performs the mode-register bring-up of a DDR2 memory on behalf of a memory controller. A single-cycle start pulse, accepted only while the block is idle, makes it take the DRAM command, address and bank pins. It then drives a fixed series of commands: a mode-register write that resets the DLL, a long fixed wait, a precharge of all banks, two refreshes, a mode-register write that releases the DLL reset, and two extended-mode-register writes that first set and then leave the default output-driver calibration.

When the last command's gap has elapsed, the block returns the pins to the controller's own command path, raises a sticky done flag, and only then starts its periodic refresh interval timer. This keeps any refresh from landing inside the bring-up. Burst length (4) and CAS latency (2) are fixed. Write recovery and the two low extended-mode bits come from configuration inputs that are captured when start is accepted.

Top module: `ddr2_init_seq`

## Requirements
- R1: While and directly after reset, the pins show NOP ({ras_n,cas_n,we_n} = 111), and address, bank address, init_done and ref_due are all zero.
- R2: A start pulse sampled in idle makes the first command visible two clocks later. That command is a mode-register write (command 000, bank 0) with only address bit 8 set (0x0100).
- R3: The precharge-all command (010, bank 0) appears exactly DLL_WAIT clocks after the first command, with only address bit 10 set (0x0400).
- R4: Exactly two refresh commands (001, address 0, bank 0) follow. The first comes T_RP clocks after the precharge and the second T_RFC clocks after the first, with only NOP between them.
- R5: T_RFC clocks after the second refresh, a mode-register write (000, bank 0) appears with address = ((cfg_wr-1) mod 8) in bits 11:9, bit 8 clear, CAS latency 010 in bits 6:4, burst type 0 in bit 3 and burst length 010 in bits 2:0.
- R6: T_MRD clocks later, an extended-mode write (000, bank 1) appears with bits 9:7 = 111 and bits 1:0 = cfg_emr, all other bits zero.
- R7: T_MRD clocks later, a second extended-mode write (000, bank 1) appears with bits 9:7 = 000 and bits 1:0 = cfg_emr, all other bits zero.
- R8: Each command lasts one clock, and every command has address bits 15:13 and bank bit 2 at zero. Between commands the pins carry NOP with address and bank at zero.
- R9: init_done rises T_MRD clocks after the last extended-mode write and stays high until reset. From the next clock on, the pins copy ctl_* with one clock of latency. Before that, ctl_* has no effect on the pins.
- R10: ref_due is a one-clock pulse. It first appears REF_INT clocks after init_done rises and then repeats every REF_INT clocks, and it never appears before init_done.
- R11: A start pulse outside idle, whether during the sequence or after done, has no effect. cfg_wr and cfg_emr are sampled only when start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, honoured only in idle |
| cfg_wr | input | 4 | Write recovery in clocks (2..8) |
| cfg_emr | input | 2 | Extended-mode bits 1:0 (driver strength, DLL enable) |
| ctl_ras_n | input | 1 | Controller path row strobe |
| ctl_cas_n | input | 1 | Controller path column strobe |
| ctl_we_n | input | 1 | Controller path write strobe |
| ctl_addr | input | ADDR_W | Controller path address |
| ctl_ba | input | BA_W | Controller path bank address |
| dram_ras_n | output | 1 | Registered row strobe to DRAM |
| dram_cas_n | output | 1 | Registered column strobe to DRAM |
| dram_we_n | output | 1 | Registered write strobe to DRAM |
| dram_addr | output | ADDR_W | Registered DRAM address |
| dram_ba | output | BA_W | Registered DRAM bank address |
| init_done | output | 1 | Sticky sequence-complete flag |
| ref_due | output | 1 | Periodic refresh request pulse |

## Verification
The bench counts clocks from the edge that takes start. The first command is due on the second sample after that edge. Each later command is due exactly one gap (DLL_WAIT, T_RP, T_RFC or T_MRD) after the one before it, done is due T_MRD after the last command, and ref_due is due REF_INT and then 2*REF_INT after done. All outputs are sampled at the falling edge, so each sample shows the result of the rising edge before it, and the sample index is compared against this precomputed schedule. Once done is high, the pins are compared with the controller inputs driven one sample earlier.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [2:0] {
    CMD_LOAD_MODE = 3'b000,
    CMD_REFRESH   = 3'b001,
    CMD_PRECHARGE = 3'b010,
    CMD_NOP       = 3'b111
  } dram_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  localparam int unsigned STEP_COUNT = 7;
  localparam int unsigned STEP_W     = 3;

  // Mode-register fixed fields: burst length 4, CAS latency 2
  localparam logic [2:0] MR_BL4 = 3'b010;
  localparam logic [2:0] MR_CL2 = 3'b010;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr2_gap_timer.sv
module ddr2_gap_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr2_cmd_table.sv
module ddr2_cmd_table
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BA_W     = 3,
  parameter int CNT_W    = 8,
  parameter int DLL_WAIT = 200,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 8,
  parameter int T_MRD    = 2
) (
  input  logic [STEP_W-1:0] step,
  input  logic [2:0]        wr_field,
  input  logic [1:0]        emr_low,
  output dram_cmd_e         cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic [CNT_W-1:0]  gap_m1
);

  always_comb begin
    cmd    = CMD_NOP;
    addr   = '0;
    ba     = '0;
    gap_m1 = '0;
    case (step)
      3'd0: begin // MR write, DLL reset requested
        cmd     = CMD_LOAD_MODE;
        addr[8] = 1'b1;
        gap_m1  = CNT_W'(DLL_WAIT - 1);
      end
      3'd1: begin // precharge all banks
        cmd      = CMD_PRECHARGE;
        addr[10] = 1'b1;
        gap_m1   = CNT_W'(T_RP - 1);
      end
      3'd2, 3'd3: begin // two refreshes
        cmd    = CMD_REFRESH;
        gap_m1 = CNT_W'(T_RFC - 1);
      end
      3'd4: begin // MR write, DLL running
        cmd        = CMD_LOAD_MODE;
        addr[11:9] = wr_field;
        addr[6:4]  = MR_CL2;
        addr[2:0]  = MR_BL4;
        gap_m1     = CNT_W'(T_MRD - 1);
      end
      3'd5: begin // EMR(1), calibration default
        cmd       = CMD_LOAD_MODE;
        ba[0]     = 1'b1;
        addr[9:7] = 3'b111;
        addr[1:0] = emr_low;
        gap_m1    = CNT_W'(T_MRD - 1);
      end
      3'd6: begin // EMR(1), calibration exit
        cmd       = CMD_LOAD_MODE;
        ba[0]     = 1'b1;
        addr[1:0] = emr_low;
        gap_m1    = CNT_W'(T_MRD - 1);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr2_ref_timer.sv
module ddr2_ref_timer #(
  parameter int REF_INT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic due
);

  localparam int RW = (REF_INT > 2) ? $clog2(REF_INT) : 1;
  localparam logic [RW-1:0] LAST = RW'(REF_INT - 1);

  logic [RW-1:0] cnt_q;
  logic          due_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else if (enable) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        due_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        due_q <= 1'b0;
      end
    end else begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end
  end

  assign due = due_q;

  a_r10_pulse_single: assert property (@(posedge clk) disable iff (rst)
    due_q |=> !due_q);

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BA_W     = 3,
  parameter int DLL_WAIT = 200,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 8,
  parameter int T_MRD    = 2,
  parameter int REF_INT  = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        cfg_wr,
  input  logic [1:0]        cfg_emr,
  input  logic              ctl_ras_n,
  input  logic              ctl_cas_n,
  input  logic              ctl_we_n,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [BA_W-1:0]   ctl_ba,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [ADDR_W-1:0] dram_addr,
  output logic [BA_W-1:0]   dram_ba,
  output logic              init_done,
  output logic              ref_due
);

  localparam int MAX_GAP = max2(max2(DLL_WAIT, T_RP), max2(T_RFC, T_MRD));
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [2:0]        wr_q;
  logic [1:0]        emr_q;
  logic [2:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BA_W-1:0]   ba_q;
  logic              done_q;

  dram_cmd_e         tbl_cmd;
  logic [ADDR_W-1:0] tbl_addr;
  logic [BA_W-1:0]   tbl_ba;
  logic [CNT_W-1:0]  tbl_gap_m1;
  logic              gap_zero;
  logic              gap_load;
  logic [CNT_W-1:0]  gap_val;
  logic              last_step;
  logic [3:0]        wr_m1;
  logic              strobe;

  assign wr_m1     = cfg_wr - 4'd1;
  assign last_step = (step_q == STEP_W'(STEP_COUNT));

  ddr2_cmd_table #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
    .DLL_WAIT(DLL_WAIT), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_table (
    .step(step_q), .wr_field(wr_q), .emr_low(emr_q),
    .cmd(tbl_cmd), .addr(tbl_addr), .ba(tbl_ba), .gap_m1(tbl_gap_m1)
  );

  always_comb begin
    gap_load = 1'b0;
    gap_val  = '0;
    if (state_q == ST_IDLE && start) begin
      gap_load = 1'b1;
    end else if (state_q == ST_RUN && gap_zero && !last_step) begin
      gap_load = 1'b1;
      gap_val  = tbl_gap_m1;
    end
  end

  ddr2_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      wr_q    <= '0;
      emr_q   <= '0;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      ba_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cmd_q  <= CMD_NOP;
          addr_q <= '0;
          ba_q   <= '0;
          if (start) begin
            state_q <= ST_RUN;
            step_q  <= '0;
            wr_q    <= wr_m1[2:0];
            emr_q   <= cfg_emr;
          end
        end
        ST_RUN: begin
          cmd_q  <= CMD_NOP;
          addr_q <= '0;
          ba_q   <= '0;
          if (gap_zero) begin
            if (last_step) begin
              state_q <= ST_DONE;
              done_q  <= 1'b1;
            end else begin
              cmd_q  <= tbl_cmd;
              addr_q <= tbl_addr;
              ba_q   <= tbl_ba;
              step_q <= step_q + 1'b1;
            end
          end
        end
        default: begin
          cmd_q  <= {ctl_ras_n, ctl_cas_n, ctl_we_n};
          addr_q <= ctl_addr;
          ba_q   <= ctl_ba;
        end
      endcase
    end
  end

  ddr2_ref_timer #(.REF_INT(REF_INT)) u_ref (
    .clk(clk), .rst(rst), .enable(done_q), .due(ref_due)
  );

  assign {dram_ras_n, dram_cas_n, dram_we_n} = cmd_q;
  assign dram_addr = addr_q;
  assign dram_ba   = ba_q;
  assign init_done = done_q;
  assign strobe    = (cmd_q != CMD_NOP);

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (!done_q && strobe) |-> ((addr_q >> 13) == '0 && ba_q[BA_W-1] == 1'b0));

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (!done_q && strobe) |=> !strobe);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);

  a_r10_ref_gated: assert property (@(posedge clk) disable iff (rst)
    ref_due |-> done_q);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> !strobe);

endmodule

// File: tb/sim_ddr2_init_seq.sv
module sim_ddr2_init_seq;

  localparam int ADDR_W   = 16;
  localparam int BA_W     = 3;
  localparam int DLL_WAIT = 200;
  localparam int T_RP     = 3;
  localparam int T_RFC    = 8;
  localparam int T_MRD    = 2;
  localparam int REF_INT  = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] cfg_wr = 4'd2;
  logic [1:0] cfg_emr = 2'd0;
  logic ctl_ras_n = 1'b1, ctl_cas_n = 1'b1, ctl_we_n = 1'b1;
  logic [ADDR_W-1:0] ctl_addr = '0;
  logic [BA_W-1:0]   ctl_ba = '0;
  logic dram_ras_n, dram_cas_n, dram_we_n;
  logic [ADDR_W-1:0] dram_addr;
  logic [BA_W-1:0]   dram_ba;
  logic init_done, ref_due;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ddr2_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .DLL_WAIT(DLL_WAIT), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .REF_INT(REF_INT)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .cfg_wr(cfg_wr), .cfg_emr(cfg_emr),
    .ctl_ras_n(ctl_ras_n), .ctl_cas_n(ctl_cas_n), .ctl_we_n(ctl_we_n),
    .ctl_addr(ctl_addr), .ctl_ba(ctl_ba),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_ba(dram_ba),
    .init_done(init_done), .ref_due(ref_due)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [21:0] pins();
    return {dram_ras_n, dram_cas_n, dram_we_n, dram_addr, dram_ba};
  endfunction

  function automatic logic [21:0] exp_pins(input logic [2:0] c,
                                           input logic [15:0] a,
                                           input logic [2:0] b);
    return {c, a, b};
  endfunction

  function automatic logic [15:0] mr_run_addr(input logic [3:0] wr);
    logic [3:0] m1;
    m1 = wr - 4'd1;
    return (16'(m1[2:0]) << 9) | 16'h0022;
  endfunction

  task automatic do_reset();
    rst   = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Runs one full bring-up with noise on every input that must be ignored.
  task automatic run_seq(input logic [3:0] wr, input logic [1:0] emr);
    int t[7];
    int done_t;
    int end_t;
    int stray = 0;
    int leak  = 0;
    int ref_bad = 0;
    logic [21:0] drv_prev;
    logic [21:0] drv_now;
    logic [21:0] expect_cmd [7];
    string tags [7];

    t[0] = 2;
    t[1] = t[0] + DLL_WAIT;
    t[2] = t[1] + T_RP;
    t[3] = t[2] + T_RFC;
    t[4] = t[3] + T_RFC;
    t[5] = t[4] + T_MRD;
    t[6] = t[5] + T_MRD;
    done_t = t[6] + T_MRD;
    end_t  = done_t + 2 * REF_INT + 3;

    expect_cmd[0] = exp_pins(3'b000, 16'h0100, 3'd0);
    expect_cmd[1] = exp_pins(3'b010, 16'h0400, 3'd0);
    expect_cmd[2] = exp_pins(3'b001, 16'h0000, 3'd0);
    expect_cmd[3] = exp_pins(3'b001, 16'h0000, 3'd0);
    expect_cmd[4] = exp_pins(3'b000, mr_run_addr(wr), 3'd0);
    expect_cmd[5] = exp_pins(3'b000, 16'h0380 | 16'(emr), 3'd1);
    expect_cmd[6] = exp_pins(3'b000, 16'(emr), 3'd1);
    tags = '{"R2", "R3", "R4", "R4", "R5", "R6", "R7"};

    cfg_wr  = wr;
    cfg_emr = emr;
    start   = 1'b1;
    drv_prev = '0;
    for (int i = 1; i <= end_t; i++) begin
      @(negedge clk);
      // sample results of the preceding rising edge
      begin
        bit hit = 1'b0;
        for (int k = 0; k < 7; k++) begin
          if (i == t[k]) begin
            hit = 1'b1;
            chk(pins() == expect_cmd[k], tags[k], $sformatf("step %0d", k),
                pins(), expect_cmd[k]);
          end
        end
        if (!hit && i <= done_t && pins() != 22'h380000) stray++;
      end
      if (i == done_t - 1)
        chk(init_done == 1'b0, "R9", "done early", init_done, 0);
      if (i == done_t)
        chk(init_done == 1'b1, "R9", "done rise", init_done, 1);
      if (i > done_t) begin
        if (!init_done) leak++;
        if (pins() != drv_prev) leak++;
      end
      if (i == done_t + REF_INT)
        chk(ref_due == 1'b1, "R10", "first refresh pulse", ref_due, 1);
      else if (i == done_t + 2 * REF_INT)
        chk(ref_due == 1'b1, "R10", "second refresh pulse", ref_due, 1);
      else if (ref_due) ref_bad++;

      // new noise: start pulses, config changes, controller path values
      start   = (($urandom % 13) == 0);
      cfg_wr  = 4'($urandom);
      cfg_emr = 2'($urandom);
      ctl_ras_n = 1'($urandom);
      ctl_cas_n = 1'($urandom);
      ctl_we_n  = 1'($urandom);
      ctl_addr  = ADDR_W'($urandom);
      ctl_ba    = BA_W'($urandom);
      drv_now   = {ctl_ras_n, ctl_cas_n, ctl_we_n, ctl_addr, ctl_ba};
      drv_prev  = drv_now;
    end
    start = 1'b0;
    chk(stray == 0, "R8", "non-NOP between commands (R11 noise)", stray, 0);
    chk(leak == 0, "R9", "pass-through after done", leak, 0);
    chk(ref_bad == 0, "R10", "stray refresh pulses", ref_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    @(negedge clk);
    chk(pins() == 22'h380000, "R1", "pins after reset", pins(), 22'h380000);
    chk(init_done == 1'b0, "R1", "done after reset", init_done, 0);
    chk(ref_due == 1'b0, "R1", "ref_due after reset", ref_due, 0);

    // idle with no start: nothing leaves the block
    repeat (5) @(negedge clk);
    chk(pins() == 22'h380000, "R2", "idle without start", pins(), 22'h380000);

    // directed corners: smallest and largest write recovery
    run_seq(4'd2, 2'd0);
    // R11: start after done changes nothing
    ctl_ras_n = 1'b1; ctl_cas_n = 1'b1; ctl_we_n = 1'b1;
    ctl_addr = '0; ctl_ba = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      chk(pins() == 22'h380000 && init_done, "R11", "start after done",
          {init_done, pins()}, {1'b1, 22'h380000});
    end

    do_reset();
    run_seq(4'd8, 2'd3);

    for (int r = 0; r < 3; r++) begin
      logic [3:0] wr;
      wr = 4'(2 + ($urandom % 7));
      do_reset();
      repeat (1 + ($urandom % 4)) @(negedge clk);
      run_seq(wr, 2'($urandom));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule